// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits between a handful of peripheral event flags and a CPU core. It gathers six requests: two external lines, three timer overflows, and a serial event that merges the receive and transmit flags. Requests are qualified by a master switch and per-source enable bits. Each source carries a priority bit that places it in a high or a low class. The winning request is offered to the core as a single request line with a fixed 16-bit vector address and a source index.

When the core takes the vector, the block pulses an acknowledge with the source index so the source can drop its flag. It also clears its own latched copy of that request and records the class now in service. A high-class request may interrupt a low-class handler. Nothing interrupts a high-class handler, and a low-class request waits while any handler runs. A return pulse from the core ends the innermost active handler.

Software programs the block through two byte-wide write ports, one for enables and one for priorities.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While a request is offered, `irq_vec` equals 0x0003 + 8 × `irq_src`. The source indices are: external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4, timer 2 = 5. With no request offered, both `irq_vec` and `irq_src` read zero.
- R2: A write to the enable port stores bit 7 as the master switch and bits 5..0 as the per-source enables, using the index order of R1. A source whose enable bit is 0 is never offered.
- R3: After reset, no enable or priority bit is set, nothing is pending, nothing is in service, and `irq_req` and `irq_ack` are low.
- R4: While the master switch is 0, `irq_req` stays low whatever is pending.
- R5: Among eligible requests of the same class, the lowest source index is offered.
- R6: A write to the priority port stores bits 5..0, with 1 meaning high class; bits 7..6 are ignored. An eligible high-class request is offered ahead of every low-class one, whatever their indices.
- R7: While only a low-class handler is in service, an eligible high-class request is offered. Low-class requests are held back.
- R8: While a high-class handler is in service, no request is offered.
- R9: The serial request is the OR of `req_ser_rx` and `req_ser_tx`.
- R10: A request flag high on a clock edge becomes pending from the next cycle. It stays pending, even if the flag drops or the source is disabled, until that source is acknowledged.
- R11: `irq_ack` is high in exactly the cycles in which `cpu_take` is high while a request is offered, with `ack_src` equal to `irq_src`. The pending bit of that source is clear in the next cycle, and the offered class is recorded as in service.
- R12: A `cpu_ret` pulse clears the high in-service bit if it is set, and otherwise the low one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| pri_we | input | 1 | Priority register write strobe |
| pri_wdata | input | 8 | Priority register write data |
| req_ext0 | input | 1 | External line 0 request flag |
| req_tmr0 | input | 1 | Timer 0 overflow flag |
| req_ext1 | input | 1 | External line 1 request flag |
| req_tmr1 | input | 1 | Timer 1 overflow flag |
| req_ser_rx | input | 1 | Serial receive flag |
| req_ser_tx | input | 1 | Serial transmit flag |
| req_tmr2 | input | 1 | Timer 2 overflow flag |
| cpu_take | input | 1 | Core accepts the offered vector |
| cpu_ret | input | 1 | Core returns from a handler |
| irq_req | output | 1 | Request offered to the core |
| irq_vec | output | 16 | Vector address of the offered request |
| irq_src | output | 3 | Index of the offered source |
| irq_ack | output | 1 | Acknowledge pulse to the sources |
| ack_src | output | 3 | Index of the acknowledged source |

## Verification
The bench builds the block with its default parameters. These include the timer 2 source, so all six vectors, enable bit 5 and priority bit 5 can be reached. The random phase changes the enable and priority registers while requests, takes and returns arrive together. This produces nested low-to-high service, blocked low requests under high service, and returns that land on an empty or half-full in-service stack. Directed steps cover the disabled-but-latched case, the reserved priority bits and a serial request raised by the transmit flag alone.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int MAX_SRC   = 6;
  localparam int IDX_W     = 3;
  localparam int MASTER_BIT = 7;

  typedef enum logic [IDX_W-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4,
    SRC_TMR2 = 3'd5
  } src_e;

  typedef struct packed {
    logic hi;
    logic lo;
  } svc_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int NSRC = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_we,
  input  logic [7:0]      en_wdata,
  input  logic            pri_we,
  input  logic [7:0]      pri_wdata,
  output logic            master_en,
  output logic [NSRC-1:0] src_en,
  output logic [NSRC-1:0] src_hi
);
  import prio_irq_pkg::*;

  logic            master_q, master_d;
  logic [NSRC-1:0] en_q, en_d;
  logic [NSRC-1:0] hi_q, hi_d;
  logic            unused_bits;

  assign unused_bits = ^{en_wdata[6], pri_wdata[7:6], en_wdata[5:NSRC-1], pri_wdata[5:NSRC-1]};

  always_comb begin
    master_d = master_q;
    en_d     = en_q;
    hi_d     = hi_q;
    if (en_we) begin
      master_d = en_wdata[MASTER_BIT];
      en_d     = en_wdata[NSRC-1:0];
    end
    if (pri_we) hi_d = pri_wdata[NSRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      en_q     <= '0;
      hi_q     <= '0;
    end else begin
      master_q <= master_d;
      en_q     <= en_d;
      hi_q     <= hi_d;
    end
  end

  assign master_en = master_q;
  assign src_en    = en_q;
  assign src_hi    = hi_q;

  p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> ($stable(src_en) && $stable(master_en)));
  p_pri_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pri_we |=> $stable(src_hi));
endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int NSRC = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] flags,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] pend
);
  logic [NSRC-1:0] pend_q, pend_d;

  always_comb begin
    pend_d = (pend_q | flags) & ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend = pend_q;

  p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr) |=> ((pend_q & $past(clr)) == '0));
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr == '0) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC  = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  pend,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NSRC-1:0]  src_hi,
  input  logic             master_en,
  input  prio_irq_pkg::svc_t insvc,
  output logic             gnt_vld,
  output logic             gnt_hi,
  output logic [IDX_W-1:0] gnt_idx
);
  logic [NSRC-1:0] hi_cand;
  logic [NSRC-1:0] lo_cand;

  for (genvar g = 0; g < NSRC; g++) begin : g_elig
    assign hi_cand[g] = master_en & src_en[g] & pend[g] &  src_hi[g];
    assign lo_cand[g] = master_en & src_en[g] & pend[g] & ~src_hi[g];
  end

  function automatic logic [IDX_W-1:0] first_set(input logic [NSRC-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (m[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  always_comb begin
    gnt_vld = 1'b0;
    gnt_hi  = 1'b0;
    gnt_idx = '0;
    if ((|hi_cand) && !insvc.hi) begin
      gnt_vld = 1'b1;
      gnt_hi  = 1'b1;
      gnt_idx = first_set(hi_cand);
    end else if ((|lo_cand) && !insvc.hi && !insvc.lo) begin
      gnt_vld = 1'b1;
      gnt_idx = first_set(lo_cand);
    end
  end

  p_hi_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && (|hi_cand)) |-> gnt_hi);
  p_hi_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    insvc.hi |-> !gnt_vld);
  p_grant_eligible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> (src_en[gnt_idx] && pend[gnt_idx]));
endmodule

// File: rtl/irq_nest_state.sv
module irq_nest_state (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_lo,
  input  logic               set_hi,
  input  logic               ret,
  output prio_irq_pkg::svc_t insvc
);
  import prio_irq_pkg::*;

  svc_t svc_q, svc_d;

  always_comb begin
    svc_d = svc_q;
    if (ret) begin
      if (svc_q.hi) svc_d.hi = 1'b0;
      else          svc_d.lo = 1'b0;
    end
    if (set_hi) svc_d.hi = 1'b1;
    if (set_lo) svc_d.lo = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc_q <= '0;
    else        svc_q <= svc_d;
  end

  assign insvc = svc_q;

  p_ret_pops_hi_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !set_hi && !set_lo && svc_q.hi && svc_q.lo) |=> (svc_q.lo && !svc_q.hi));
  p_lo_from_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_lo |-> (!svc_q.hi && !svc_q.lo));
  p_one_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_lo && set_hi));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter bit HAS_TMR2   = 1'b1,
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_we,
  input  logic [7:0]  en_wdata,
  input  logic        pri_we,
  input  logic [7:0]  pri_wdata,
  input  logic        req_ext0,
  input  logic        req_tmr0,
  input  logic        req_ext1,
  input  logic        req_tmr1,
  input  logic        req_ser_rx,
  input  logic        req_ser_tx,
  input  logic        req_tmr2,
  input  logic        cpu_take,
  input  logic        cpu_ret,
  output logic        irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic [2:0]  irq_src,
  output logic        irq_ack,
  output logic [2:0]  ack_src
);
  import prio_irq_pkg::*;

  localparam int NSRC = HAS_TMR2 ? MAX_SRC : MAX_SRC - 1;

  logic                 rst_sync_n;
  logic                 master_en;
  logic [NSRC-1:0]      src_en, src_hi, pend, clr, flags;
  logic [MAX_SRC-1:0]   raw_flags;
  svc_t                 insvc;
  logic                 gnt_vld, gnt_hi, take_ok;
  logic [IDX_W-1:0]     gnt_idx;

  irq_rst_sync i_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  irq_cfg_regs #(.NSRC(NSRC)) i_cfg (
    .clk(clk), .rst_n(rst_sync_n),
    .en_we(en_we), .en_wdata(en_wdata),
    .pri_we(pri_we), .pri_wdata(pri_wdata),
    .master_en(master_en), .src_en(src_en), .src_hi(src_hi)
  );

  always_comb begin
    raw_flags           = '0;
    raw_flags[SRC_EXT0] = req_ext0;
    raw_flags[SRC_TMR0] = req_tmr0;
    raw_flags[SRC_EXT1] = req_ext1;
    raw_flags[SRC_TMR1] = req_tmr1;
    raw_flags[SRC_SER]  = req_ser_rx | req_ser_tx;
    raw_flags[SRC_TMR2] = req_tmr2;
  end

  assign flags = raw_flags[NSRC-1:0];

  irq_pend_latch #(.NSRC(NSRC)) i_pend (
    .clk(clk), .rst_n(rst_sync_n),
    .flags(flags), .clr(clr), .pend(pend)
  );

  irq_arbiter #(.NSRC(NSRC), .IDX_W(IDX_W)) i_arb (
    .clk(clk), .rst_n(rst_sync_n),
    .pend(pend), .src_en(src_en), .src_hi(src_hi),
    .master_en(master_en), .insvc(insvc),
    .gnt_vld(gnt_vld), .gnt_hi(gnt_hi), .gnt_idx(gnt_idx)
  );

  assign take_ok = cpu_take & gnt_vld;
  assign clr     = take_ok ? (NSRC'(1) << gnt_idx) : '0;

  irq_nest_state i_nest (
    .clk(clk), .rst_n(rst_sync_n),
    .set_lo(take_ok & ~gnt_hi), .set_hi(take_ok & gnt_hi),
    .ret(cpu_ret), .insvc(insvc)
  );

  assign irq_req = gnt_vld;
  assign irq_src = gnt_vld ? gnt_idx : '0;
  assign irq_vec = gnt_vld ? VEC_W'(VEC_BASE + VEC_STRIDE * int'(gnt_idx)) : '0;
  assign irq_ack = take_ok;
  assign ack_src = take_ok ? gnt_idx : '0;

  p_off_silent_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !master_en |-> !irq_req);
  p_vec_aligned_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_req |-> ((int'(irq_vec) - VEC_BASE) % VEC_STRIDE == 0));
  p_ack_needs_req_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_ack |-> (irq_req && ack_src == irq_src));
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int CYC = 20;

  logic clk = 1'b0;
  always #(CYC/2) clk = ~clk;

  logic        rst_n;
  logic        en_we, pri_we;
  logic [7:0]  en_wd, pri_wd;
  logic        e0, t0, e1, t1, rx, tx, t2;
  logic        take, ret;
  logic        irq_req, irq_ack;
  logic [15:0] irq_vec;
  logic [2:0]  irq_src, ack_src;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0] m_en, m_pri;
  logic [5:0] m_pend;
  logic [1:0] m_isv;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .en_we(en_we), .en_wdata(en_wd), .pri_we(pri_we), .pri_wdata(pri_wd),
    .req_ext0(e0), .req_tmr0(t0), .req_ext1(e1), .req_tmr1(t1),
    .req_ser_rx(rx), .req_ser_tx(tx), .req_tmr2(t2),
    .cpu_take(take), .cpu_ret(ret),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_src(irq_src),
    .irq_ack(irq_ack), .ack_src(ack_src)
  );

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int lowest(logic [5:0] m);
    int r = 0;
    for (int i = 5; i >= 0; i--) if (m[i]) r = i;
    return r;
  endfunction

  task automatic exp_grant(output bit v, output int idx, output bit hi);
    logic [5:0] hc, lc;
    hc = m_en[7] ? (m_pend & m_en[5:0] &  m_pri[5:0]) : 6'd0;
    lc = m_en[7] ? (m_pend & m_en[5:0] & ~m_pri[5:0]) : 6'd0;
    v = 1'b0; idx = 0; hi = 1'b0;
    if (hc != 0 && !m_isv[1]) begin
      v = 1'b1; hi = 1'b1; idx = lowest(hc);
    end else if (lc != 0 && m_isv == 2'b00) begin
      v = 1'b1; idx = lowest(lc);
    end
  endtask

  task automatic idle();
    en_we = 0; pri_we = 0; en_wd = 0; pri_wd = 0;
    e0 = 0; t0 = 0; e1 = 0; t1 = 0; rx = 0; tx = 0; t2 = 0;
    take = 0; ret = 0;
  endtask

  // Called at a falling edge with inputs already set; returns at the next falling edge.
  task automatic step(string tag);
    bit v, hi, acc;
    int idx;
    logic [5:0] fl, clr;
    exp_grant(v, idx, hi);
    acc = take && v;
    #5;
    check(tag,  "irq_req", int'(irq_req), int'(v));
    check("R1", "irq_vec", int'(irq_vec), v ? 3 + 8 * idx : 0);
    check("R1", "irq_src", int'(irq_src), v ? idx : 0);
    check("R11", "irq_ack", int'(irq_ack), int'(acc));
    if (acc) check("R11", "ack_src", int'(ack_src), idx);
    fl  = {t2, rx | tx, t1, e1, t0, e0};
    clr = acc ? 6'(1 << idx) : 6'd0;
    m_pend = (m_pend | fl) & ~clr;
    if (ret) begin
      if (m_isv[1]) m_isv[1] = 1'b0;
      else          m_isv[0] = 1'b0;
    end
    if (acc) begin
      if (hi) m_isv[1] = 1'b1;
      else    m_isv[0] = 1'b1;
    end
    if (en_we)  m_en  = en_wd & 8'hBF;
    if (pri_we) m_pri = pri_wd & 8'h3F;
    @(negedge clk);
  endtask

  initial begin
    #(CYC * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    m_en = 0; m_pri = 0; m_pend = 0; m_isv = 0;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R3: quiet while held in reset
    check("R3", "irq_req", int'(irq_req), 0);
    check("R3", "irq_ack", int'(irq_ack), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    step("R3");
    // R2: flag with nothing enabled is not offered (but latches)
    e0 = 1; step("R2"); idle();
    // R4: source enabled, master switch off
    en_we = 1; en_wd = 8'h01; step("R4"); idle();
    step("R4");
    // R10: latched request appears once master switch is set
    en_we = 1; en_wd = 8'hBF; step("R10"); idle();
    step("R10");
    take = 1; step("R11"); idle();
    step("R11");
    ret = 1; step("R12"); idle();
    // R6: ext1 high class, reserved bits set in the write
    pri_we = 1; pri_wd = 8'hC4; step("R6"); idle();
    e0 = 1; e1 = 1; step("R6"); idle();
    step("R6");
    // R7: low service, then high preempts
    pri_we = 1; pri_wd = 8'h00; step("R7"); idle();
    take = 1; step("R7"); idle();
    pri_we = 1; pri_wd = 8'h04; step("R7"); idle();
    t0 = 1; step("R7"); idle();
    take = 1; step("R7"); idle();
    // R8: high in service blocks everything
    step("R8");
    step("R8");
    ret = 1; step("R12"); idle();
    step("R12");
    ret = 1; step("R12"); idle();
    step("R12");
    take = 1; step("R11"); idle();
    ret = 1; step("R12"); idle();
    // R9: serial via transmit flag only
    tx = 1; step("R9"); idle();
    step("R9");
    take = 1; step("R9"); idle();
    ret = 1; step("R9"); idle();
    // R5: timer1 and timer0 both low, timer0 wins
    pri_we = 1; pri_wd = 8'h00; step("R5"); idle();
    t1 = 1; t0 = 1; step("R5"); idle();
    step("R5");
    take = 1; step("R5"); idle();
    ret = 1; step("R5"); idle();
    step("R5");

    for (int n = 0; n < 4000; n++) begin
      idle();
      e0 = ($urandom % 8) == 0;
      t0 = ($urandom % 8) == 0;
      e1 = ($urandom % 8) == 0;
      t1 = ($urandom % 8) == 0;
      rx = ($urandom % 16) == 0;
      tx = ($urandom % 16) == 0;
      t2 = ($urandom % 8) == 0;
      take = ($urandom % 3) == 0;
      ret  = ($urandom % 6) == 0;
      if (($urandom % 40) == 0) begin
        en_we = 1;
        en_wd = 8'($urandom);
        if (($urandom % 8) != 0) en_wd[7] = 1'b1;
      end
      if (($urandom % 40) == 0) begin
        pri_we = 1;
        pri_wd = 8'($urandom);
      end
      step("R5");
    end
    idle();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule